// File: doc/BRIEF.md
# Condition Flag Evaluator

This block stores the four arithmetic condition flags (negative, zero, carry, overflow) and decides whether a 4-bit condition field is satisfied by them. It drives one pass/fail bit that a sequencer can use to commit or squash a conditional operation. The pass/fail output is combinational from the stored flags and the condition field, so a condition presented in a cycle is judged against the flags held in that cycle.

The flags can change in two ways. An arithmetic unit can hand over a new flag nibble on a per-cycle enable. Software can write a 32-bit status word whose top four bits carry the flags. If both happen in the same cycle, the software write wins. The same 32-bit packing is always available on a read port. Every status-word bit other than the four flag bits reads as zero.

Top module: `cond_flag_unit`

## Requirements
- R1: Code 0000 passes when Z=1 and code 0001 passes when Z=0. Code 0010 passes when C=1 and code 0011 passes when C=0.
- R2: Code 0100 passes when N=1 and code 0101 passes when N=0. Code 0110 passes when V=1 and code 0111 passes when V=0.
- R3: Code 1000 (unsigned higher) passes when C=1 and Z=0. Code 1001 (unsigned lower or same) passes when C=0 or Z=1.
- R4: Code 1010 passes when N equals V. Code 1011 passes when N differs from V. Code 1100 passes when Z=0 and N equals V. Code 1101 passes when Z=1 or N differs from V.
- R5: Code 1110 always passes and code 1111 never passes, whatever the flags are.
- R6: When `sw_wr_en` is high, a clock edge loads the flags from `sw_wr_data` (N from bit 31, Z from bit 30, C from bit 29, V from bit 28). `sw_rd_data` presents the flags at those same bit positions.
- R7: When `alu_upd_en` is high and `sw_wr_en` is low, a clock edge loads the flags from `alu_flags`, packed as {N,Z,C,V} in bits 3 down to 0.
- R8: When `sw_wr_en` and `alu_upd_en` are both high in the same cycle, the flags take the status-word value and `alu_flags` has no effect.
- R9: When neither enable is high, the flags hold their value at a clock edge, whatever `sw_wr_data` and `alu_flags` are.
- R10: Bits 27 to 0 of `sw_rd_data` always read as zero, even after a write with those bits set.
- R11: A clock edge with `rst` high clears all four flags to zero. This takes priority over both update paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_wr_en | input | 1 | Status-word write strobe |
| sw_wr_data | input | 32 | Status word to load, with the flags in bits 31..28 |
| sw_rd_data | output | 32 | Status-word readback, with the flags in bits 31..28 and the other bits zero |
| alu_upd_en | input | 1 | Flag update enable from the arithmetic unit |
| alu_flags | input | 4 | New flags from the arithmetic unit, packed as {N,Z,C,V} |
| cond_code | input | 4 | Condition field to evaluate |
| cond_pass | output | 1 | High when the condition is satisfied by the current flags |

## Verification
The flags are the only state. A write or update presented in one cycle becomes visible on `sw_rd_data` after the next rising edge. `cond_pass` has no register of its own, so it follows `cond_code` with no delay and follows the flags in the same cycle in which they change. The bench drives inputs on the falling edge and queues the values that are due after the following rising edge. The monitor samples a quarter period after that rising edge, so each expected item is matched against exactly one edge's result.

// File: rtl/cond_flag_unit.sv
module cond_flag_unit #(
  parameter int STATUS_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sw_wr_en,
  input  logic [STATUS_W-1:0] sw_wr_data,
  output logic [STATUS_W-1:0] sw_rd_data,
  input  logic                alu_upd_en,
  input  logic [3:0]          alu_flags,
  input  logic [3:0]          cond_code,
  output logic                cond_pass
);
  localparam int NB = STATUS_W - 1;
  localparam int ZB = STATUS_W - 2;
  localparam int CB = STATUS_W - 3;
  localparam int VB = STATUS_W - 4;

  logic f_n, f_z, f_c, f_v;
  logic base;

  always_ff @(posedge clk) begin
    if (rst) begin
      {f_n, f_z, f_c, f_v} <= 4'b0000;
    end else if (sw_wr_en) begin
      {f_n, f_z, f_c, f_v} <= {sw_wr_data[NB], sw_wr_data[ZB], sw_wr_data[CB], sw_wr_data[VB]};
    end else if (alu_upd_en) begin
      {f_n, f_z, f_c, f_v} <= alu_flags;
    end
  end

  assign sw_rd_data = {f_n, f_z, f_c, f_v, {(STATUS_W-4){1'b0}}};

  // Each pair of codes shares one test; the low bit of the code inverts it.
  always_comb begin
    case (cond_code[3:1])
      3'd0: base = f_z;
      3'd1: base = f_c;
      3'd2: base = f_n;
      3'd3: base = f_v;
      3'd4: base = f_c & ~f_z;
      3'd5: base = ~(f_n ^ f_v);
      3'd6: base = ~f_z & ~(f_n ^ f_v);
      default: base = 1'b1;
    endcase
  end

  assign cond_pass = base ^ cond_code[0];
endmodule

module cond_flag_unit_chk #(
  parameter int STATUS_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                sw_wr_en,
  input logic [STATUS_W-1:0] sw_wr_data,
  input logic [STATUS_W-1:0] sw_rd_data,
  input logic                alu_upd_en,
  input logic [3:0]          alu_flags,
  input logic [3:0]          cond_code,
  input logic                cond_pass
);
  localparam int T = STATUS_W - 1;

  p_reset_clear_r11: assert property (@(posedge clk) rst |=> (sw_rd_data[T -: 4] == 4'b0000));
  p_sw_load_r6: assert property (@(posedge clk) disable iff (rst)
    sw_wr_en |=> (sw_rd_data[T -: 4] == $past(sw_wr_data[T -: 4])));
  p_wr_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (sw_wr_en && alu_upd_en) |=> (sw_rd_data[T -: 4] == $past(sw_wr_data[T -: 4])));
  p_alu_load_r7: assert property (@(posedge clk) disable iff (rst)
    (alu_upd_en && !sw_wr_en) |=> (sw_rd_data[T -: 4] == $past(alu_flags)));
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!sw_wr_en && !alu_upd_en) |=> $stable(sw_rd_data));
  p_always_r5: assert property (@(posedge clk) disable iff (rst)
    (cond_code == 4'b1110) |-> cond_pass);
  p_never_r5: assert property (@(posedge clk) disable iff (rst)
    (cond_code == 4'b1111) |-> !cond_pass);
  p_eq_r1: assert property (@(posedge clk) disable iff (rst)
    (cond_code == 4'b0000) |-> (cond_pass == sw_rd_data[T-1]));
  p_ge_r4: assert property (@(posedge clk) disable iff (rst)
    (cond_code == 4'b1010) |-> (cond_pass == (sw_rd_data[T] == sw_rd_data[T-3])));
endmodule

bind cond_flag_unit cond_flag_unit_chk #(.STATUS_W(STATUS_W)) chk_i (
  .clk(clk), .rst(rst), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
  .sw_rd_data(sw_rd_data), .alu_upd_en(alu_upd_en), .alu_flags(alu_flags),
  .cond_code(cond_code), .cond_pass(cond_pass)
);

// File: tb/cond_flag_unit_tb.sv
module cond_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_wr_en = 1'b0;
  logic [31:0] sw_wr_data = '0;
  logic [31:0] sw_rd_data;
  logic        alu_upd_en = 1'b0;
  logic [3:0]  alu_flags = '0;
  logic [3:0]  cond_code = '0;
  logic        cond_pass;

  int checks = 0;
  int errors = 0;
  logic [3:0] model = 4'b0000;

  logic [31:0] q_rd[$];
  logic        q_pass[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  cond_flag_unit dut_i (
    .clk(clk), .rst(rst), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .sw_rd_data(sw_rd_data), .alu_upd_en(alu_upd_en), .alu_flags(alu_flags),
    .cond_code(cond_code), .cond_pass(cond_pass)
  );

  function automatic logic ref_pass(input logic [3:0] f, input logic [3:0] cc);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string cc_tag(input logic [3:0] cc);
    if (cc < 4) return "R1";
    if (cc < 8) return "R2";
    if (cc < 10) return "R3";
    if (cc < 14) return "R4";
    return "R5";
  endfunction

  task automatic step(input logic r, input logic we, input logic [31:0] wd,
                      input logic ue, input logic [3:0] af, input logic [3:0] cc,
                      input string tag);
    @(negedge clk);
    rst = r; sw_wr_en = we; sw_wr_data = wd; alu_upd_en = ue; alu_flags = af; cond_code = cc;
    if (r) model = 4'b0000;
    else if (we) model = wd[31:28];
    else if (ue) model = af;
    q_rd.push_back({model, 28'h0});
    q_pass.push_back(ref_pass(model, cc));
    q_tag.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #5;
      if (q_rd.size() > 0) begin
        logic [31:0] er;
        logic ep;
        string tg;
        er = q_rd.pop_front();
        ep = q_pass.pop_front();
        tg = q_tag.pop_front();
        checks++;
        if (sw_rd_data !== er) begin
          errors++;
          $display("FAIL %s: sw_rd_data actual %h expected %h", tg, sw_rd_data, er);
        end
        checks++;
        if (cond_pass !== ep) begin
          errors++;
          $display("FAIL %s: cond_pass actual %b expected %b (code %b)", tg, cond_pass, ep, cond_code);
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    step(1, 0, 32'h0, 0, 4'h0, 4'd0, "R11");
    step(1, 1, 32'hF000_0000, 1, 4'hF, 4'd0, "R11");
    for (int f = 0; f < 16; f++) begin
      step(0, 1, {f[3:0], 28'h0}, 0, 4'h0, 4'd14, "R6");
      for (int cc = 0; cc < 16; cc++)
        step(0, 0, 32'h0, 0, 4'h0, cc[3:0], cc_tag(cc[3:0]));
    end
    step(0, 1, 32'h5FFF_FFFF, 0, 4'h0, 4'd1, "R10");
    step(0, 0, 32'hFFFF_FFFF, 0, 4'h0, 4'd5, "R10");
    step(0, 0, 32'hA000_0000, 1, 4'b1001, 4'd10, "R7");
    step(0, 0, 32'h0, 1, 4'b0110, 4'd8, "R7");
    step(0, 0, 32'h0, 1, 4'b1000, 4'd11, "R7");
    step(0, 1, 32'h3000_0000, 1, 4'b1100, 4'd9, "R8");
    step(0, 1, 32'h8000_0000, 1, 4'b0011, 4'd12, "R8");
    step(0, 0, 32'hFFFF_FFFF, 0, 4'hF, 4'd13, "R9");
    step(0, 0, 32'h0000_0000, 0, 4'h0, 4'd4, "R9");
    step(1, 1, 32'hF000_0000, 1, 4'hF, 4'd0, "R11");
    step(0, 0, 32'h0, 0, 4'h0, 4'd14, "R5");
    step(0, 0, 32'h0, 0, 4'h0, 4'd15, "R5");
    repeat (3) @(posedge clk);
    #6;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule